// File: doc/BRIEF.md
# Banked Address Decoder with Wait States

This block sits between a processor's 24-bit address bus and the memories and register windows behind it. The upper eight bits of the address select a bank and the lower sixteen an offset within it. From that pair the block raises one chip select, for work RAM, a peripheral register bus window, the processor's internal register block or cartridge ROM. It also produces the linear work RAM offset and the linear ROM offset. A small window of low work RAM is reachable from most banks. ROM is laid out in one of two arrangements picked by a layout input: 32 KiB slices in the upper half of each bank, or whole 64 KiB banks.

Every access also gets a speed. ROM reads in the upper half of the bank space can run fast when fast ROM is enabled, except for DMA. Work RAM and unmapped space are always slow. The two register windows are always fast. A request strobe starts a wait-state countdown that holds `ready_o` low for the chosen number of clocks. Reads from unmapped space return the last value the data bus carried.

Top module: `addr_map_decode`

## Requirements
- R1: Banks 0x7E and 0x7F select work RAM at every offset, with RAM offset = {bank bit 0, 16-bit offset}, so bank 0x7F reaches distinct storage from 0x7E.
- R2: In the mirror banks (bank bit 6 clear: 0x00–0x3F, 0x80–0xBF), offsets 0x0000–0x1FFF select work RAM with RAM offset equal to the offset, independent of the bank.
- R3: In the mirror banks, offsets 0x2100–0x21FF raise `cs_pbus_o` and offsets 0x4000–0x43FF raise `cs_creg_o`.
- R4: With `hi_map_i`=0, every bank other than 0x7E/0x7F at offsets 0x8000–0xFFFF is a ROM read with ROM offset = {bank[6:0], offset[14:0]} AND `rom_mask_i`.
- R5: With `hi_map_i`=1, banks 0x40–0x7D and 0xC0–0xFF at any offset, and the mirror banks at offsets 0x8000–0xFFFF, are ROM reads with ROM offset = {bank[5:0], offset} AND `rom_mask_i`.
- R6: An address matching none of R1–R5 raises no chip select, and `rdata_o` then shows the last bus value: the write data of the last completed write, or the device data of the last completed read of a mapped region.
- R7: A write whose address decodes to ROM raises no chip select.
- R8: `fast_o` is 1 for peripheral and register windows, 1 for a ROM read in a bank at or above 0x80 when `fast_rom_i`=1 and `dma_i`=0, and 0 for everything else (work RAM, unmapped, DMA ROM reads, lower-bank ROM).
- R9: `ready_o` is 1 after reset and while idle. After a clock edge that samples `req_i`=1 it is 0 for 8 cycles when `fast_o` was 0 at that edge, or 6 cycles when it was 1, and then returns to 1.
- R10: A request sampled while a countdown runs reloads the counter from that request's speed.
- R11: A ROM image smaller than 4 MiB, described by a power-of-two-minus-one `rom_mask_i`, repeats through the ROM space.
- R12: At most one chip select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start-of-access strobe |
| addr_i | input | 24 | Bank (23:16) and offset (15:0) |
| wr_i | input | 1 | 1 for a write access |
| dma_i | input | 1 | Access issued by the DMA engine |
| hi_map_i | input | 1 | ROM layout: 0 = 32 KiB slices, 1 = 64 KiB banks |
| fast_rom_i | input | 1 | Enables fast ROM reads in banks 0x80 and up |
| rom_mask_i | input | 22 | ROM size minus one |
| wdata_i | input | 8 | Write data driven on the bus |
| rdata_dev_i | input | 8 | Read data from the selected device |
| rdata_o | output | 8 | Read data to the processor, open bus when unmapped |
| cs_wram_o | output | 1 | Work RAM select |
| cs_pbus_o | output | 1 | Peripheral register bus select |
| cs_creg_o | output | 1 | Internal register block select |
| cs_rom_o | output | 1 | ROM select (reads only) |
| ram_addr_o | output | 17 | Linear work RAM offset |
| rom_addr_o | output | 22 | Linear ROM offset |
| fast_o | output | 1 | Current access runs at the fast rate |
| ready_o | output | 1 | Access complete, bus free |

## Verification
The hardest state to reach is the open-bus value seen at an unmapped address. It depends on the history of earlier accesses, not on the present address. The bench builds that history through full timed accesses: a RAM write, then a ROM read with known device data. It then moves to unmapped space, and an unmapped access must leave the held value unchanged. The reload case needs a second strobe placed in the middle of a slow countdown. The bench places it a fixed number of negative edges after the first strobe and counts the total low time. Decode itself is swept over all 256 banks against a set of offsets on every region edge, under both layouts, for reads and writes, with DMA and with a reduced ROM mask.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  localparam int BANK_W   = 8;
  localparam int OFF_W    = 16;
  localparam int ADDR_W   = BANK_W + OFF_W;
  localparam int RAM_AW   = OFF_W + 1;
  localparam int ROM_AW   = BANK_W - 2 + OFF_W;
  localparam int MIRROR_W = 13;
  localparam int HALF_W   = OFF_W - 1;

  localparam logic [BANK_W-2:0] WRAM_BANK_PAIR = 7'h3F;
  localparam logic [7:0]        PBUS_PAGE      = 8'h21;
  localparam logic [5:0]        CREG_KPAGE     = 6'h10;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_WRAM = 3'd1,
    RGN_PBUS = 3'd2,
    RGN_CREG = 3'd3,
    RGN_ROM  = 3'd4
  } region_e;
endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
  import addr_map_pkg::*;
(
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              hi_map_i,
  input  logic              wr_i,
  input  logic [ROM_AW-1:0] rom_mask_i,
  output region_e           region_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o
);
  logic              sys_bank;
  logic              wram_bank;
  logic              low_win;
  logic [ROM_AW-1:0] rom_lin;
  logic [ROM_AW-1:0] rom_lo;
  logic [ROM_AW-1:0] rom_hi;
  region_e           rgn;

  assign sys_bank  = ~bank_i[BANK_W-2];
  assign wram_bank = (bank_i[BANK_W-1:1] == WRAM_BANK_PAIR);
  assign low_win   = (off_i[OFF_W-1:MIRROR_W] == '0);

  // slice layout drops offset msb, page layout drops bank bits 7:6
  assign rom_lo = {bank_i[BANK_W-2:0], off_i[HALF_W-1:0]};
  assign rom_hi = {bank_i[BANK_W-3:0], off_i};

  always_comb begin
    rgn        = RGN_NONE;
    ram_addr_o = '0;
    rom_lin    = '0;
    if (wram_bank) begin
      rgn        = RGN_WRAM;
      ram_addr_o = {bank_i[0], off_i};
    end else if (sys_bank && low_win) begin
      rgn        = RGN_WRAM;
      ram_addr_o = RAM_AW'(off_i[MIRROR_W-1:0]);
    end else if (sys_bank && off_i[OFF_W-1:8] == PBUS_PAGE) begin
      rgn = RGN_PBUS;
    end else if (sys_bank && off_i[OFF_W-1:10] == CREG_KPAGE) begin
      rgn = RGN_CREG;
    end else if (hi_map_i) begin
      if (!sys_bank || off_i[OFF_W-1]) begin
        rgn     = RGN_ROM;
        rom_lin = rom_hi;
      end
    end else if (off_i[OFF_W-1]) begin
      rgn     = RGN_ROM;
      rom_lin = rom_lo;
    end
    // ROM is read-only: a write selects nothing
    if (rgn == RGN_ROM && wr_i) rgn = RGN_NONE;
  end

  assign region_o   = rgn;
  assign rom_addr_o = rom_lin & rom_mask_i;
endmodule

// File: rtl/access_speed.sv
module access_speed
  import addr_map_pkg::*;
(
  input  region_e region_i,
  input  logic    upper_bank_i,
  input  logic    fast_rom_i,
  input  logic    dma_i,
  output logic    fast_o
);
  always_comb begin
    unique case (region_i)
      RGN_PBUS, RGN_CREG: fast_o = 1'b1;
      RGN_ROM:            fast_o = upper_bank_i & fast_rom_i & ~dma_i;
      default:            fast_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int SLOW_CLKS = 8,
  parameter int FAST_CLKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fast_i,
  output logic ready_o,
  output logic done_o
);
  localparam int MAX_CLKS = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CLKS);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CLKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (req_i)       cnt_q <= fast_i ? FAST_LD : SLOW_LD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
  assign done_o  = (cnt_q == CNT_W'(1)) && !req_i;

  AST_REQ_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !ready_o); // R9
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !ready_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
  AST_IDLE_STAYS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && ready_o) |=> ready_o); // R9
endmodule

// File: rtl/open_bus_latch.sv
module open_bus_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              wr_i,
  input  logic              mapped_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_dev_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= '0;
    else if (done_i) begin
      if (wr_i)          bus_q <= wdata_i;
      else if (mapped_i) bus_q <= rdata_dev_i;
    end
  end

  assign rdata_o = mapped_i ? rdata_dev_i : bus_q;

  AST_OPEN_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(bus_q)); // R6
endmodule

// File: rtl/addr_map_decode.sv
module addr_map_decode
  import addr_map_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SLOW_CLKS = 8,
  parameter int FAST_CLKS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              dma_i,
  input  logic              hi_map_i,
  input  logic              fast_rom_i,
  input  logic [ROM_AW-1:0] rom_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_dev_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_wram_o,
  output logic              cs_pbus_o,
  output logic              cs_creg_o,
  output logic              cs_rom_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              fast_o,
  output logic              ready_o
);
  region_e rgn;
  logic    done;
  logic    mapped;

  addr_region_decode u_dec (
    .bank_i     (addr_i[ADDR_W-1:OFF_W]),
    .off_i      (addr_i[OFF_W-1:0]),
    .hi_map_i   (hi_map_i),
    .wr_i       (wr_i),
    .rom_mask_i (rom_mask_i),
    .region_o   (rgn),
    .ram_addr_o (ram_addr_o),
    .rom_addr_o (rom_addr_o)
  );

  access_speed u_spd (
    .region_i     (rgn),
    .upper_bank_i (addr_i[ADDR_W-1]),
    .fast_rom_i   (fast_rom_i),
    .dma_i        (dma_i),
    .fast_o       (fast_o)
  );

  wait_timer #(.SLOW_CLKS(SLOW_CLKS), .FAST_CLKS(FAST_CLKS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .fast_i  (fast_o),
    .ready_o (ready_o),
    .done_o  (done)
  );

  assign cs_wram_o = (rgn == RGN_WRAM);
  assign cs_pbus_o = (rgn == RGN_PBUS);
  assign cs_creg_o = (rgn == RGN_CREG);
  assign cs_rom_o  = (rgn == RGN_ROM);
  assign mapped    = (rgn != RGN_NONE);

  open_bus_latch #(.DATA_W(DATA_W)) u_obl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .wr_i        (wr_i),
    .mapped_i    (mapped),
    .wdata_i     (wdata_i),
    .rdata_dev_i (rdata_dev_i),
    .rdata_o     (rdata_o)
  );

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cs_wram_o, cs_pbus_o, cs_creg_o, cs_rom_o})); // R12
  AST_ROM_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !cs_rom_o); // R7
  AST_DMA_ROM_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_i && cs_rom_o) |-> !fast_o); // R8
  AST_WRAM_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_wram_o |-> !fast_o); // R8
endmodule

// File: tb/addr_map_decode_bench.sv
module addr_map_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic        dma = 1'b0;
  logic        hi_map = 1'b0;
  logic        fast_rom = 1'b0;
  logic [21:0] rom_mask = 22'h3FFFFF;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdev = '0;
  logic [7:0]  rdata;
  logic        cs_wram, cs_pbus, cs_creg, cs_rom;
  logic [16:0] ram_addr;
  logic [21:0] rom_addr;
  logic        fast, ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int e_rgn, e_ram, e_rom, e_fast;

  always #4 clk = ~clk;

  addr_map_decode u_addr_map_decode (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr),
    .dma_i(dma), .hi_map_i(hi_map), .fast_rom_i(fast_rom), .rom_mask_i(rom_mask),
    .wdata_i(wdata), .rdata_dev_i(rdev), .rdata_o(rdata),
    .cs_wram_o(cs_wram), .cs_pbus_o(cs_pbus), .cs_creg_o(cs_creg), .cs_rom_o(cs_rom),
    .ram_addr_o(ram_addr), .rom_addr_o(rom_addr), .fast_o(fast), .ready_o(ready)
  );

  task automatic check(input string req_tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (addr 0x%06h hi %0d wr %0d)",
               req_tag, what, act, exp, addr, hi_map, wr);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input int bank, input int off);
    bit mirror;
    mirror = (bank <= 'h3F) || (bank >= 'h80 && bank <= 'hBF);
    e_rgn = 0; e_ram = 0; e_rom = 0;
    if (bank == 'h7E || bank == 'h7F) begin
      e_rgn = 1; e_ram = (bank - 'h7E) * 65536 + off;
    end else if (mirror && off < 'h2000) begin
      e_rgn = 1; e_ram = off;
    end else if (mirror && off >= 'h2100 && off < 'h2200) e_rgn = 2;
    else if (mirror && off >= 'h4000 && off < 'h4400) e_rgn = 3;
    else if (hi_map) begin
      if (!mirror || off >= 'h8000) begin
        e_rgn = 4; e_rom = (bank % 64) * 65536 + off;
      end
    end else if (off >= 'h8000) begin
      e_rgn = 4; e_rom = (bank % 128) * 32768 + (off - 32768);
    end
    e_rom = e_rom & int'(rom_mask);
    if (e_rgn == 4 && wr) e_rgn = 0;
    e_fast = (e_rgn == 2 || e_rgn == 3) ||
             (e_rgn == 4 && fast_rom && bank >= 'h80 && !dma);
  endtask

  function automatic string tag_of(input int rgn, input int bank, input int off);
    if (wr && rgn == 0 && off >= 'h8000) return "R7";
    case (rgn)
      1: return (bank == 'h7E || bank == 'h7F) ? "R1" : "R2";
      2, 3: return "R3";
      4: return hi_map ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic probe(input int bank, input int off, input string force_tag);
    int cs_act, cs_exp;
    string t;
    addr = 24'(bank * 65536 + off);
    #1;
    model(bank, off);
    t = (force_tag != "") ? force_tag : tag_of(e_rgn, bank, off);
    cs_act = {28'd0, cs_rom, cs_creg, cs_pbus, cs_wram};
    cs_exp = (e_rgn == 0) ? 0 : (1 << (e_rgn - 1));
    check(t, cs_act, cs_exp, "chip selects (R12 one-hot)");
    if (e_rgn == 1) check(t, int'(ram_addr), e_ram, "ram offset");
    if (e_rgn == 4) check(t, int'(rom_addr), e_rom, "rom offset");
    check((e_rgn == 4 || force_tag == "R8") ? "R8" : t, int'(fast), e_fast, "speed");
  endtask

  task automatic sweep(input string force_tag);
    int offs[18] = '{'h0000, 'h1234, 'h1FFF, 'h2000, 'h20FF, 'h2100, 'h21FF, 'h2200,
                     'h3FFF, 'h4000, 'h43FF, 'h4400, 'h7FFF, 'h8000, 'hA100, 'hFFFF,
                     'h5555, 'hC3C3};
    for (int b = 0; b < 256; b++)
      for (int k = 0; k < 18; k++) probe(b, offs[k], force_tag);
  endtask

  // one timed access; returns number of low-ready samples
  task automatic access(input int a, input bit w, input int wd, input int rd, output int lows);
    @(negedge clk);
    addr = 24'(a); wr = w; wdata = 8'(wd); rdev = 8'(rd); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lows = 0;
    while (!ready && lows < 40) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    int lows;
    #3;
    check("R9", int'(ready), 1, "ready in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(ready), 1, "ready after reset");
    check("R6", int'(rdata), 0, "open bus after reset at unmapped 0x000000? n/a");

    fast_rom = 1'b1;
    for (int h = 0; h < 2; h++)
      for (int w = 0; w < 2; w++) begin
        hi_map = h[0]; wr = w[0];
        sweep("");
      end
    wr = 1'b0;

    dma = 1'b1;
    for (int h = 0; h < 2; h++) begin hi_map = h[0]; sweep("R8"); end
    dma = 1'b0; fast_rom = 1'b0;
    hi_map = 1'b0; sweep("R8");

    fast_rom = 1'b1;
    rom_mask = 22'h01FFFF;
    for (int h = 0; h < 2; h++) begin hi_map = h[0]; sweep("R11"); end
    hi_map = 1'b0;
    probe('h84, 'h9234, "R11");
    check("R11", int'(rom_addr), 'h1234, "128 KiB image repeat");
    rom_mask = 22'h3FFFFF;

    // timing: slow RAM, fast upper-bank ROM, slow lower-bank ROM, fast register window
    access('h7E0010, 1'b1, 'hA5, 0, lows);
    check("R9", lows, 8, "slow cycles (work RAM write)");
    access('h808000, 1'b0, 0, 'h3C, lows);
    check("R9", lows, 6, "fast cycles (upper ROM)");
    access('h008000, 1'b0, 0, 'h3C, lows);
    check("R9", lows, 8, "slow cycles (lower ROM)");
    access('h002100, 1'b0, 0, 'h3C, lows);
    check("R9", lows, 6, "fast cycles (peripheral window)");
    dma = 1'b1;
    access('hC08000, 1'b0, 0, 'h3C, lows);
    check("R8", lows, 8, "DMA ROM read slow");
    dma = 1'b0;

    // open bus history
    access('h7E0020, 1'b1, 'h5A, 'h00, lows);
    addr = 24'h003000; rdev = 8'hEE; #1;
    check("R6", int'(rdata), 'h5A, "open bus after write");
    access('h018000, 1'b0, 0, 'h3C, lows);
    addr = 24'h005000; rdev = 8'h11; #1;
    check("R6", int'(rdata), 'h3C, "open bus after ROM read");
    access('h006000, 1'b0, 0, 'h77, lows);
    #1;
    check("R6", int'(rdata), 'h3C, "unmapped read leaves bus value");
    access('h018000, 1'b1, 'h99, 'h00, lows);
    check("R7", int'(cs_rom), 0, "write to ROM keeps select low");
    addr = 24'h003000; #1;
    check("R6", int'(rdata), 'h99, "ROM write data seen on bus");

    // reload mid countdown
    @(negedge clk);
    addr = 24'h7E0000; wr = 1'b0; req = 1'b1;
    @(negedge clk); req = 1'b0; lows = 1;
    @(negedge clk); lows++;
    @(negedge clk); lows++;
    check("R10", int'(ready), 0, "busy before reload");
    addr = 24'h808000; req = 1'b1;
    @(negedge clk); req = 1'b0;
    while (!ready && lows < 40) begin
      lows++;
      @(negedge clk);
    end
    check("R10", lows, 9, "reload total low cycles");

    finished = 1;
    summary();
  end
endmodule